// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit of a multicycle processor datapath. It holds a 4-bit encoded state. On every clock it combines that state with the 6-bit opcode taken from the instruction register and computes the next state. It also computes the full set of datapath control strobes and select fields for the state it enters. Instructions run through a shared fetch state and a shared decode state. Each instruction then follows its own short chain of execute, memory and write-back states, and the machine returns to fetch.

The next state is built the way a two-plane logic array builds it. An AND plane forms product terms. Each term is one full state code, optionally qualified by an exact opcode. An OR plane then sums the terms into the four next-state bits. No more than one product term may be active in any cycle. When no term matches, nothing drives the OR plane and the machine goes back to fetch. The control outputs are decoded from the next state and registered, so they change on the same edge as the state register.

The opcode is expected to stay constant from decode until the instruction's last state, because it comes from the instruction register.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts `state` to 0 (fetch) on the next rising edge, from any state. The outputs then show the fetch control word.
- R2: In state 0 the outputs are as follows. `pc_wr`=1 and `ir_wr`=1. `mem_addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00. `rf_wr`=0. The next state is 1.
- R3: In state 1 (decode) the outputs are as follows. `pc_wr`, `ir_wr` and `rf_wr` are all 0. `alu_b_sel`=11 and `sign_ext`=1. The next state depends on the opcode:
  - 000000 (register-register) goes to 6.
  - 100011 (load) goes to 2.
  - 101011 (store) goes to 2.
  - 000100 (branch-equal) goes to 8.
  - 000010 (jump) goes to 9.
  - 001000 (add-immediate) goes to 10.
  - Any other opcode goes to 0.
- R4: Register-register path. State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10 (function-field add), then goes to 7. State 7 drives `rf_wr`=1, `dst_sel`=1 and `wb_sel`=0, then goes to 0.
- R5: Load path. State 2 drives `alu_a_sel`=1, `alu_b_sel`=10, `alu_op`=00 and `sign_ext`=1, and goes to 3 for a load. State 3 drives `mem_addr_sel`=1 and goes to 4. State 4 drives `rf_wr`=1, `dst_sel`=0 and `wb_sel`=1, then goes to 0.
- R6: Store path. From state 2 a store goes to 5. State 5 drives `mem_addr_sel`=1 and `mem_wr`=1, then goes to 0.
- R7: Branch state 8 drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01, then goes to 0.
- R8: Jump state 9 drives `pc_wr`=1 and `pc_src`=10, then goes to 0.
- R9: Add-immediate path. State 10 drives `alu_a_sel`=1, `alu_b_sel`=10, `alu_op`=00 and `sign_ext`=1, then goes to 11. State 11 drives `rf_wr`=1, `dst_sel`=0 and `wb_sel`=0, then goes to 0.
- R10: `rf_wr` is 1 only in states 4, 7 and 11. Every output not named for a state in R2 to R9 is 0 in that state.
- R11: No more than one next-state product term is active in a cycle. When none is active, the next state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| state | output | 4 | Current state code |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when ALU result is zero |
| mem_addr_sel | output | 1 | Memory address: 0 program counter, 1 ALU result register |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| dst_sel | output | 1 | Destination register: 0 second source field, 1 destination field |
| rf_wr | output | 1 | Register file write |
| wb_sel | output | 1 | Write-back data: 0 ALU result register, 1 memory data |
| alu_a_sel | output | 1 | ALU A input: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 from function field |
| pc_src | output | 2 | Next PC source: 00 ALU, 01 ALU result register, 10 jump target |
| sign_ext | output | 1 | Sign-extend the immediate |

## Verification
The bench builds the block with its default widths: a 4-bit state and a 6-bit opcode with twelve product terms. At these sizes every one of the 64 opcodes can be run from reset through the whole instruction, holding the opcode fixed, and every control bit can be compared in every state visited. This sweep covers each path and also every unrecognised opcode that falls back to fetch from decode. A further sequence asserts reset part-way through a load, so the return to fetch is seen from a state other than fetch.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  localparam int ST_W    = 4;
  localparam int OPC_W   = 6;
  localparam int N_TERMS = 12;

  localparam logic [ST_W-1:0] ST_FETCH  = 4'd0;
  localparam logic [ST_W-1:0] ST_DECODE = 4'd1;
  localparam logic [ST_W-1:0] ST_ADDR   = 4'd2;
  localparam logic [ST_W-1:0] ST_MRD    = 4'd3;
  localparam logic [ST_W-1:0] ST_LDWB   = 4'd4;
  localparam logic [ST_W-1:0] ST_MWR    = 4'd5;
  localparam logic [ST_W-1:0] ST_REXE   = 4'd6;
  localparam logic [ST_W-1:0] ST_RWB    = 4'd7;
  localparam logic [ST_W-1:0] ST_BEQ    = 4'd8;
  localparam logic [ST_W-1:0] ST_JMP    = 4'd9;
  localparam logic [ST_W-1:0] ST_IEXE   = 4'd10;
  localparam logic [ST_W-1:0] ST_IWB    = 4'd11;

  localparam logic [OPC_W-1:0] OPC_RR   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LD   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_ST   = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_ANY  = 6'b000000;
  localparam logic [OPC_W-1:0] M_ALL    = 6'b111111;
  localparam logic [OPC_W-1:0] M_NONE   = 6'b000000;

  typedef struct packed {
    logic [ST_W-1:0]  cur;
    logic [OPC_W-1:0] opc;
    logic [OPC_W-1:0] msk;
    logic [ST_W-1:0]  nxt;
  } term_t;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       mem_addr_sel;
    logic       mem_wr;
    logic       ir_wr;
    logic       dst_sel;
    logic       rf_wr;
    logic       wb_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       sign_ext;
  } ctrl_t;

  // AND-plane row contents: state match, opcode match under mask, target
  function automatic term_t term_at(input int idx);
    term_t t;
    case (idx)
      0:  t = '{ST_FETCH,  OPC_ANY,  M_NONE, ST_DECODE};
      1:  t = '{ST_DECODE, OPC_RR,   M_ALL,  ST_REXE};
      2:  t = '{ST_DECODE, OPC_LD,   M_ALL,  ST_ADDR};
      3:  t = '{ST_DECODE, OPC_ST,   M_ALL,  ST_ADDR};
      4:  t = '{ST_DECODE, OPC_BEQ,  M_ALL,  ST_BEQ};
      5:  t = '{ST_DECODE, OPC_JMP,  M_ALL,  ST_JMP};
      6:  t = '{ST_DECODE, OPC_ADDI, M_ALL,  ST_IEXE};
      7:  t = '{ST_ADDR,   OPC_LD,   M_ALL,  ST_MRD};
      8:  t = '{ST_ADDR,   OPC_ST,   M_ALL,  ST_MWR};
      9:  t = '{ST_MRD,    OPC_ANY,  M_NONE, ST_LDWB};
      10: t = '{ST_REXE,   OPC_ANY,  M_NONE, ST_RWB};
      11: t = '{ST_IEXE,   OPC_ANY,  M_NONE, ST_IWB};
      default: t = '{ST_FETCH, OPC_ANY, M_NONE, ST_FETCH};
    endcase
    return t;
  endfunction

  // OR-plane column for one next-state bit
  function automatic logic [N_TERMS-1:0] col_mask(input int bitpos);
    logic [N_TERMS-1:0] m;
    term_t t;
    m = '0;
    for (int k = 0; k < N_TERMS; k++) begin
      t = term_at(k);
      m[k] = t.nxt[bitpos];
    end
    return m;
  endfunction

  function automatic ctrl_t ctrl_of(input logic [ST_W-1:0] s);
    ctrl_t c;
    c = '0;
    case (s)
      ST_FETCH:  begin c.pc_wr = 1'b1; c.ir_wr = 1'b1; c.alu_b_sel = 2'b01; end
      ST_DECODE: begin c.alu_b_sel = 2'b11; c.sign_ext = 1'b1; end
      ST_ADDR:   begin c.alu_a_sel = 1'b1; c.alu_b_sel = 2'b10; c.sign_ext = 1'b1; end
      ST_MRD:    c.mem_addr_sel = 1'b1;
      ST_LDWB:   begin c.rf_wr = 1'b1; c.wb_sel = 1'b1; end
      ST_MWR:    begin c.mem_addr_sel = 1'b1; c.mem_wr = 1'b1; end
      ST_REXE:   begin c.alu_a_sel = 1'b1; c.alu_op = 2'b10; end
      ST_RWB:    begin c.rf_wr = 1'b1; c.dst_sel = 1'b1; end
      ST_BEQ:    begin c.alu_a_sel = 1'b1; c.alu_op = 2'b01;
                       c.pc_wr_cond = 1'b1; c.pc_src = 2'b01; end
      ST_JMP:    begin c.pc_wr = 1'b1; c.pc_src = 2'b10; end
      ST_IEXE:   begin c.alu_a_sel = 1'b1; c.alu_b_sel = 2'b10; c.sign_ext = 1'b1; end
      ST_IWB:    c.rf_wr = 1'b1;
      default:   c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mcf_and_plane.sv
module mcf_and_plane #(
  parameter int ST_W    = mcf_pkg::ST_W,
  parameter int OPC_W   = mcf_pkg::OPC_W,
  parameter int N_TERMS = mcf_pkg::N_TERMS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ST_W-1:0]    cur_st,
  input  logic [OPC_W-1:0]   opc,
  output logic [N_TERMS-1:0] hit
);

  for (genvar i = 0; i < N_TERMS; i++) begin : g_row
    localparam mcf_pkg::term_t ROW = mcf_pkg::term_at(i);
    assign hit[i] = (cur_st == ROW.cur) && ((opc & ROW.msk) == (ROW.opc & ROW.msk));
  end

  // R11: rows must never overlap
  a_r11_single_term: assert property (@(posedge clk) disable iff (rst) $onehot0(hit));

endmodule

// File: rtl/mcf_or_plane.sv
module mcf_or_plane #(
  parameter int ST_W    = mcf_pkg::ST_W,
  parameter int N_TERMS = mcf_pkg::N_TERMS
) (
  input  logic [N_TERMS-1:0] hit,
  output logic [ST_W-1:0]    ns
);

  for (genvar b = 0; b < ST_W; b++) begin : g_col
    localparam logic [N_TERMS-1:0] COL = mcf_pkg::col_mask(b);
    assign ns[b] = |(hit & COL);
  end

endmodule

// File: rtl/mcf_ctrl_decode.sv
module mcf_ctrl_decode #(
  parameter int ST_W = mcf_pkg::ST_W
) (
  input  logic [ST_W-1:0] st,
  output mcf_pkg::ctrl_t  ctl
);

  always_comb ctl = mcf_pkg::ctrl_of(st);

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter int ST_W    = mcf_pkg::ST_W,
  parameter int OPC_W   = mcf_pkg::OPC_W,
  parameter int N_TERMS = mcf_pkg::N_TERMS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic [ST_W-1:0]  state,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             mem_addr_sel,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             dst_sel,
  output logic             rf_wr,
  output logic             wb_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic [1:0]       pc_src,
  output logic             sign_ext
);

  logic [N_TERMS-1:0] hit;
  logic [ST_W-1:0]    ns;
  logic [ST_W-1:0]    st_d;
  logic [ST_W-1:0]    st_q;
  mcf_pkg::ctrl_t     ctl_d;
  mcf_pkg::ctrl_t     ctl_q;

  mcf_and_plane #(.ST_W(ST_W), .OPC_W(OPC_W), .N_TERMS(N_TERMS)) u_and (
    .clk(clk), .rst(rst), .cur_st(st_q), .opc(opcode), .hit(hit)
  );

  mcf_or_plane #(.ST_W(ST_W), .N_TERMS(N_TERMS)) u_or (
    .hit(hit), .ns(ns)
  );

  // control word is decoded for the state about to be entered, then registered
  assign st_d = rst ? mcf_pkg::ST_FETCH : ns;

  mcf_ctrl_decode #(.ST_W(ST_W)) u_dec (.st(st_d), .ctl(ctl_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= mcf_pkg::ST_FETCH;
      ctl_q <= ctl_d;
    end else begin
      st_q  <= ns;
      ctl_q <= ctl_d;
    end
  end

  assign state        = st_q;
  assign pc_wr        = ctl_q.pc_wr;
  assign pc_wr_cond   = ctl_q.pc_wr_cond;
  assign mem_addr_sel = ctl_q.mem_addr_sel;
  assign mem_wr       = ctl_q.mem_wr;
  assign ir_wr        = ctl_q.ir_wr;
  assign dst_sel      = ctl_q.dst_sel;
  assign rf_wr        = ctl_q.rf_wr;
  assign wb_sel       = ctl_q.wb_sel;
  assign alu_a_sel    = ctl_q.alu_a_sel;
  assign alu_b_sel    = ctl_q.alu_b_sel;
  assign alu_op       = ctl_q.alu_op;
  assign pc_src       = ctl_q.pc_src;
  assign sign_ext     = ctl_q.sign_ext;

  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd0) |=> (state == 4'd1));
  a_r3_decode_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1) |-> (!pc_wr && !ir_wr && !rf_wr));
  a_r4_rr_exec_to_wb: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd6) |=> (state == 4'd7));
  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd9) |-> (pc_wr && pc_src == 2'b10));
  a_r10_regwrite_states: assert property (@(posedge clk) disable iff (rst)
    rf_wr |-> (state == 4'd4 || state == 4'd7 || state == 4'd11));
  a_r10_pc_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr && pc_wr_cond));

endmodule

// File: tb/sim_mc_ctrl_fsm.sv
module sim_mc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] state;
  logic pc_wr, pc_wr_cond, mem_addr_sel, mem_wr, ir_wr, dst_sel, rf_wr, wb_sel, alu_a_sel, sign_ext;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mc_ctrl_fsm u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .state(state),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
    .mem_wr(mem_wr), .ir_wr(ir_wr), .dst_sel(dst_sel), .rf_wr(rf_wr),
    .wb_sel(wb_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .alu_op(alu_op), .pc_src(pc_src), .sign_ext(sign_ext)
  );

  // expected next state from the requirement text
  function automatic logic [3:0] exp_next(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd1: case (op)
              6'b000000: return 4'd6;
              6'b100011: return 4'd2;
              6'b101011: return 4'd2;
              6'b000100: return 4'd8;
              6'b000010: return 4'd9;
              6'b001000: return 4'd10;
              default:   return 4'd0;
            endcase
      4'd2: return (op == 6'b100011) ? 4'd3 : ((op == 6'b101011) ? 4'd5 : 4'd0);
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      4'd10: return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  // {pc_wr,pc_wr_cond,mem_addr_sel,mem_wr,ir_wr,dst_sel,rf_wr,wb_sel,alu_a_sel} alu_b_sel alu_op pc_src sign_ext
  function automatic logic [15:0] exp_ctl(input logic [3:0] s);
    case (s)
      4'd0:  return 16'b100010000_01_00_00_0;
      4'd1:  return 16'b000000000_11_00_00_1;
      4'd2:  return 16'b000000001_10_00_00_1;
      4'd3:  return 16'b001000000_00_00_00_0;
      4'd4:  return 16'b000000110_00_00_00_0;
      4'd5:  return 16'b001100000_00_00_00_0;
      4'd6:  return 16'b000000001_00_10_00_0;
      4'd7:  return 16'b000001100_00_00_00_0;
      4'd8:  return 16'b010000001_00_01_01_0;
      4'd9:  return 16'b100000000_00_00_10_0;
      4'd10: return 16'b000000001_10_00_00_1;
      4'd11: return 16'b000000100_00_00_00_0;
      default: return 16'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd6, 4'd7: return "R4";
      4'd2, 4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10, 4'd11: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] act_ctl();
    return {pc_wr, pc_wr_cond, mem_addr_sel, mem_wr, ir_wr, dst_sel, rf_wr, wb_sel,
            alu_a_sel, alu_b_sel, alu_op, pc_src, sign_ext};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [3:0] es);
    logic [15:0] ec;
    ec = exp_ctl(es);
    n_chk++;
    if (state !== es || act_ctl() !== ec) begin
      n_bad++;
      $display("FAIL %s op=%b state act=%0d exp=%0d ctrl act=%b exp=%b",
               req, opcode, state, es, act_ctl(), ec);
    end
  endtask

  initial begin
    logic [3:0] es;
    // exhaustive opcode sweep: every path R2..R9, fallback R11, R10 zeros
    for (int op = 0; op < 64; op++) begin
      #1;
      rst = 1'b1;
      opcode = op[5:0];
      step();
      check("R1", 4'd0);
      rst = 1'b0;
      es = 4'd0;
      for (int k = 0; k < 6; k++) begin
        es = exp_next(es, op[5:0]);
        step();
        check((es == 4'd0) ? "R11" : req_of(es), es);
        if (es == 4'd0) break;
      end
    end
    // R1: reset in the middle of a load
    rst = 1'b1; opcode = 6'b100011;
    step();
    rst = 1'b0;
    step(); step(); step();
    check("R5", 4'd3);
    rst = 1'b1;
    step();
    check("R1", 4'd0);
    rst = 1'b0;
    step();
    check("R2", 4'd1);
    // R10: store from decode back to fetch, then new instruction fetch
    opcode = 6'b101011;
    step(); check("R6", 4'd2);
    step(); check("R6", 4'd5);
    step(); check("R10", 4'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule